// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is the master half of an I2C controller, steered one bus event at a time through a small register file. Software requests a START, a repeated START or a STOP, and supplies the address byte or data bytes. The engine drives the open-drain SCL and SDA lines as active-low enables. SCL timing comes from a programmable divider.

After each bus event the engine raises an event flag and posts an 8-bit status code. While the flag is set it parks SCL low. Software reads the code and decides the next action. It writes the control register with the flag bit at zero, and that write lets the engine continue. If the engine loses arbitration or sees a bus error, it releases both lines and reports the fact with its own code.

Registers by offset: 0 is data, 1 is control, 2 is status (read only), 3 is clock setup, and 4 is the reset strobe (write only).

Top module: `i2cm_engine`

## Requirements
- R1: The reset state is control = 0x00, status = 0xF8, clock setup = 0x00, both line enables off and irq low. The control register at offset 1 reads back bit 7 interrupt enable, bit 6 bus enable, bit 5 START request, bit 4 STOP request, bit 3 event flag and bit 2 acknowledge enable. Bits 1:0 read as zero. irq is high exactly when the interrupt enable and the event flag are both set.
- R2: A START from an idle bus posts status 0x08. A repeated START, requested while the engine is parked, posts 0x10. While the flag is set after any event other than 0x38 or 0x00, scl_oe stays asserted.
- R3: The first byte after a START or repeated START is the address byte. Bit 0 of that byte is the direction bit, and 0 means write. An address byte with direction write posts 0x18 on ACK and 0x20 on NACK. A data byte sent by the master posts 0x28 on ACK and 0x30 on NACK. Bytes go out MSB first, and SDA does not change while SCL is released within a bit.
- R4: An address byte with direction read posts 0x40 on ACK and 0x48 on NACK. Each byte received after that posts 0x50 if the master returned ACK and 0x58 if it returned NACK. The received byte can then be read at offset 0.
- R5: The acknowledge enable bit is sampled when a received byte begins. Changing that bit during the byte has no effect on the ACK or NACK the master returns for that byte.
- R6: Status reads 0xF8 whenever the flag is clear. Writing 1 to the flag bit cannot set the flag.
- R7: Clearing the flag with the STOP request set produces a STOP and leaves both lines released. If the STOP and START requests are set in the same write, the STOP is sent first and is followed by a fresh START that posts 0x08.
- R8: The clock setup register holds an exponent N in bits 2:0 and a scalar M in bits 6:3. The SCL period is 10·(M+1)·2^N system clocks.
- R9: The master loses arbitration when it leaves SDA released during an address or data bit but SDA reads low at the end of the SCL high time. It then posts 0x38 and releases both lines.
- R10: A change on SDA in the middle of an SCL high time within a byte is a bus error. The engine posts 0x00 and releases both lines.
- R11: Any write to offset 4 returns the whole block to its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Event interrupt |

## Verification
The START request and the STOP request can both take effect on the same flag-clearing write. The bench provokes this by writing both bits at once while the engine is parked after a received byte. It judges the result from two things: the bus slave model must count a new STOP, and the next event posted must be 0x08 rather than 0x10. A second overlap, a control write landing in the middle of a received byte, checks that the ACK decision stays with the value sampled when the byte began.

// File: rtl/i2cm_engine.sv
`timescale 1ns/1ps
module i2cm_engine #(
  parameter int DIV_W = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       irq
);
  localparam logic [2:0] A_DAT = 3'd0, A_CTL = 3'd1, A_STS = 3'd2, A_CLK = 3'd3, A_RST = 3'd4;
  localparam logic [7:0] C_BERR = 8'h00, C_ST = 8'h08, C_RST = 8'h10, C_AW_A = 8'h18, C_AW_N = 8'h20,
                         C_DW_A = 8'h28, C_DW_N = 8'h30, C_LOST = 8'h38, C_AR_A = 8'h40,
                         C_AR_N = 8'h48, C_DR_A = 8'h50, C_DR_N = 8'h58, C_NONE = 8'hF8;

  typedef enum logic [2:0] {S_IDLE, S_START, S_RSTART, S_STOP, S_BIT, S_HOLD, S_FREE} st_t;
  typedef enum logic [1:0] {OP_ADDR, OP_TX, OP_RX} op_t;

  st_t              st;
  op_t              op;
  logic [DIV_W-1:0] cnt;
  logic [1:0]       step;
  logic [3:0]       bitn;
  logic             ph, sref, ackq, rwq, aft, rdm;
  logic [7:0]       dat, stat;
  logic             ien, enab, sta, sto, flag, aak;
  logic [6:0]       ccr;
  logic             scl_lo, sda_lo;
  logic [31:0]      half_w;
  logic             hd;
  logic [7:0]       rcode;
  logic             in_bit, at_idle;

  assign half_w  = (32'd5 * (32'(ccr[6:3]) + 32'd1)) << ccr[2:0];
  assign hd      = (32'(cnt) == half_w - 32'd1);
  assign scl_oe  = scl_lo;
  assign sda_oe  = sda_lo;
  assign irq     = ien & flag;
  assign in_bit  = (st == S_BIT);
  assign at_idle = (st == S_IDLE);

  always_comb begin
    case (op)
      OP_ADDR: rcode = rwq ? (sda_in ? C_AR_N : C_AR_A) : (sda_in ? C_AW_N : C_AW_A);
      OP_TX:   rcode = sda_in ? C_DW_N : C_DW_A;
      default: rcode = ackq ? C_DR_A : C_DR_N;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_DAT:   reg_rdata = dat;
      A_CTL:   reg_rdata = {ien, enab, sta, sto, flag, aak, 2'b00};
      A_STS:   reg_rdata = flag ? stat : C_NONE;
      A_CLK:   reg_rdata = {1'b0, ccr};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (reg_we && reg_addr == A_RST)) begin
      st <= S_IDLE; op <= OP_ADDR; cnt <= '0; step <= '0; bitn <= '0;
      ph <= 1'b0; sref <= 1'b1; ackq <= 1'b0; rwq <= 1'b0; aft <= 1'b0; rdm <= 1'b0;
      dat <= '0; stat <= C_NONE; ien <= 1'b0; enab <= 1'b0; sta <= 1'b0; sto <= 1'b0;
      flag <= 1'b0; aak <= 1'b0; ccr <= '0; scl_lo <= 1'b0; sda_lo <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          scl_lo <= 1'b0; sda_lo <= 1'b0; cnt <= '0; step <= '0;
          if (enab && sta && !flag) begin st <= S_START; sta <= 1'b0; end
        end
        S_START: begin
          if (hd) begin
            cnt <= '0;
            if (step == 2'd0) begin sda_lo <= 1'b1; step <= 2'd1; end
            else begin scl_lo <= 1'b1; stat <= C_ST; flag <= 1'b1; aft <= 1'b1; st <= S_HOLD; end
          end else cnt <= cnt + 1'b1;
        end
        S_RSTART: begin
          if (hd) begin
            cnt <= '0; step <= step + 2'd1;
            case (step)
              2'd0: scl_lo <= 1'b0;
              2'd1: sda_lo <= 1'b1;
              default: begin scl_lo <= 1'b1; stat <= C_RST; flag <= 1'b1; aft <= 1'b1; rdm <= 1'b0; st <= S_HOLD; end
            endcase
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: begin
          if (hd) begin
            cnt <= '0; step <= step + 2'd1;
            case (step)
              2'd0: scl_lo <= 1'b0;
              2'd1: sda_lo <= 1'b0;
              default: begin st <= S_IDLE; aft <= 1'b0; rdm <= 1'b0; end
            endcase
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: begin
          if (!flag) begin
            cnt <= '0; step <= '0;
            if (sto) begin sto <= 1'b0; sda_lo <= 1'b1; st <= S_STOP; end
            else if (sta) begin sta <= 1'b0; sda_lo <= 1'b0; st <= S_RSTART; end
            else begin
              st <= S_BIT; bitn <= '0; ph <= 1'b0; ackq <= aak;
              if (aft) begin op <= OP_ADDR; rwq <= dat[0]; aft <= 1'b0; end
              else op <= rdm ? OP_RX : OP_TX;
            end
          end
        end
        S_BIT: begin
          if (!ph) begin
            if (cnt == '0)
              sda_lo <= (bitn == 4'd8) ? (op == OP_RX && ackq) : (op != OP_RX && !dat[7]);
            if (hd) begin cnt <= '0; ph <= 1'b1; scl_lo <= 1'b0; end
            else cnt <= cnt + 1'b1;
          end else begin
            if (cnt == '0) sref <= sda_in;
            if (cnt != '0 && sda_in != sref) begin
              stat <= C_BERR; flag <= 1'b1; scl_lo <= 1'b0; sda_lo <= 1'b0; st <= S_FREE;
            end else if (hd) begin
              cnt <= '0; ph <= 1'b0;
              if (op != OP_RX && bitn != 4'd8 && !sda_lo && !sda_in) begin
                stat <= C_LOST; flag <= 1'b1; scl_lo <= 1'b0; sda_lo <= 1'b0; st <= S_FREE;
              end else begin
                scl_lo <= 1'b1;
                if (bitn != 4'd8) begin
                  dat <= {dat[6:0], sda_in}; bitn <= bitn + 4'd1;
                end else begin
                  flag <= 1'b1; stat <= rcode; st <= S_HOLD;
                  if (op == OP_ADDR) rdm <= rwq;
                end
              end
            end else if (scl_in) cnt <= cnt + 1'b1;
          end
        end
        S_FREE: begin
          scl_lo <= 1'b0; sda_lo <= 1'b0; aft <= 1'b0; rdm <= 1'b0;
          if (!flag) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase

      if (!enab) begin st <= S_IDLE; scl_lo <= 1'b0; sda_lo <= 1'b0; end

      if (reg_we) begin
        case (reg_addr)
          A_DAT: if (st != S_BIT) dat <= reg_wdata;
          A_CTL: begin
            ien <= reg_wdata[7]; enab <= reg_wdata[6]; sta <= reg_wdata[5];
            sto <= reg_wdata[4]; aak <= reg_wdata[2];
            if (!reg_wdata[3] && flag) flag <= 1'b0;
          end
          A_CLK: ccr <= reg_wdata[6:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cm_engine_chk.sv
`timescale 1ns/1ps
module i2cm_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic       flag,
  input logic       enab,
  input logic [7:0] stat,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       in_bit,
  input logic       at_idle
);
  AST_SCL_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && enab && stat != 8'h38 && stat != 8'h00) |-> scl_oe); // R2
  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bit && !scl_oe && $past(in_bit && !scl_oe)) |-> $stable(sda_oe)); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    at_idle |-> (!scl_oe && !sda_oe)); // R7
  AST_FAULT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && (stat == 8'h38 || stat == 8'h00)) |-> (!scl_oe && !sda_oe)); // R9
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd4) |=> (!flag && !scl_oe && !sda_oe)); // R11
endmodule

bind i2cm_engine i2cm_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .flag(flag),
  .enab(enab), .stat(stat), .scl_oe(scl_oe), .sda_oe(sda_oe), .in_bit(in_bit),
  .at_idle(at_idle)
);

// File: tb/i2cm_engine_bench.sv
`timescale 1ns/1ps
module i2cm_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd2;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, irq, scl_in, sda_in;
  logic s_drv = 1'b0, rival = 1'b0;

  always #4 clk = ~clk;

  assign scl_in = ~scl_oe;
  assign sda_in = ~(sda_oe | s_drv | rival);

  i2cm_engine u_i2cm_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .irq(irq)
  );

  int total = 0, bad = 0;
  bit done = 0;
  bit m_ien = 0;
  logic [7:0] m_code = 8'hF8;

  task automatic ck(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model on the bus
  localparam int P_NONE = 0, P_ADR = 1, P_RX = 2, P_TX = 3;
  logic [6:0] s_adr = 7'h5A;
  bit s_nack = 0;
  byte unsigned rxq[$], txq[$];
  int stops = 0, sph = P_NONE;
  bit act = 0, ps = 1, pd = 1, mt = 0, mack = 0;
  int bc = 0;
  logic [7:0] sh = 0, txb = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      act = 0; ps = 1; pd = 1; sph = P_NONE; s_drv <= 1'b0;
    end else begin
      if (ps && scl_in && pd && !sda_in) begin
        act = 1; bc = 0; sph = P_ADR; s_drv <= 1'b0;
      end else if (ps && scl_in && !pd && sda_in) begin
        act = 0; sph = P_NONE; s_drv <= 1'b0; stops++;
      end else if (act && scl_in && !ps) begin
        if (bc < 8) sh = {sh[6:0], sda_in};
        else if (bc == 8 && sph == P_TX) mack = !sda_in;
        bc++;
      end else if (act && !scl_in && ps) begin
        if (bc == 8) begin
          case (sph)
            P_ADR: begin mt = (sh[7:1] == s_adr); s_drv <= mt; end
            P_RX: begin rxq.push_back(sh); s_drv <= !s_nack; s_nack = 0; end
            default: s_drv <= 1'b0;
          endcase
        end else if (bc == 9) begin
          bc = 0;
          if ((sph == P_ADR && mt && sh[0]) || (sph == P_TX && mack)) begin
            sph = P_TX;
            txb = (txq.size() > 0) ? txq.pop_front() : 8'hFF;
            s_drv <= ~txb[7];
          end else if (sph == P_ADR && mt) begin
            sph = P_RX; s_drv <= 1'b0;
          end else if (sph == P_RX) begin
            s_drv <= 1'b0;
          end else begin
            sph = P_NONE; s_drv <= 1'b0;
          end
        end else if (sph == P_TX && bc > 0 && bc < 8) begin
          s_drv <= ~txb[7-bc];
        end
      end
      ps = scl_in; pd = sda_in;
    end
  end

  // per-clock comparison against the model
  always begin
    @(posedge clk); #2;
    if (rst_n && !done) begin
      if (m_ien && !irq && reg_addr == 3'd2) ck("R6 idle status", reg_rdata, 8'hF8);
      if (irq && m_code != 8'h38 && m_code != 8'h00) ck("R2 scl parked", scl_oe, 1);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    if (a == 3'd1) m_ien = d[7];
    if (a == 3'd4) m_ien = 0;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd2;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; #1; v = reg_rdata;
    reg_addr = 3'd2;
  endtask

  task automatic wait_irq(input string req);
    for (int i = 0; i < 20000 && !irq; i++) @(negedge clk);
    if (!irq) ck({req, " event timeout"}, 0, 1);
  endtask

  task automatic op(input logic [7:0] ctl, input logic [7:0] exp, input string req);
    logic [7:0] v;
    m_code = exp;
    wr(3'd1, ctl);
    wait_irq(req);
    rd(3'd2, v);
    ck(req, v, exp);
  endtask

  task automatic measure(output int n);
    do @(negedge clk); while (scl_oe);
    n = 0;
    do begin @(negedge clk); n++; end while (!scl_oe);
    do begin @(negedge clk); n++; end while (scl_oe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int per, s0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd1, v); ck("R1 reset control", v, 8'h00);
    rd(3'd2, v); ck("R1 reset status", v, 8'hF8);
    rd(3'd3, v); ck("R1 reset clock setup", v, 8'h00);
    ck("R1 reset lines", {scl_oe, sda_oe, irq}, 0);

    wr(3'd1, 8'hC4);
    rd(3'd1, v); ck("R1 control readback", v, 8'hC4);
    wr(3'd3, 8'h09);
    rd(3'd3, v); ck("R8 clock setup readback", v, 8'h09);
    wr(3'd1, 8'hCC);
    repeat (3) @(negedge clk);
    ck("R6 flag not settable irq", irq, 0);
    rd(3'd2, v); ck("R6 flag not settable status", v, 8'hF8);

    // write transfer, slow clock
    op(8'hE4, 8'h08, "R2 start");
    wr(3'd0, 8'hB4);
    fork
      op(8'hC4, 8'h18, "R3 addr write ack");
      measure(per);
    join
    ck("R8 scl period M=1 N=1", per, 40);
    wr(3'd0, 8'h3C);
    op(8'hC4, 8'h28, "R3 data ack");
    s_nack = 1;
    wr(3'd0, 8'h99);
    op(8'hC4, 8'h30, "R3 data nack");
    s0 = stops;
    wr(3'd1, 8'hD4);
    repeat (100) @(negedge clk);
    ck("R7 stop seen", stops, s0 + 1);
    ck("R7 lines released", {scl_oe, sda_oe}, 0);
    rd(3'd2, v); ck("R7 status after stop", v, 8'hF8);
    ck("R3 bytes at slave", rxq.size(), 2);
    if (rxq.size() == 2) begin
      ck("R3 first byte", rxq[0], 8'h3C);
      ck("R3 second byte", rxq[1], 8'h99);
    end

    // read transfer, fast clock
    wr(3'd3, 8'h00);
    txq.push_back(8'hA5); txq.push_back(8'h0F);
    op(8'hE4, 8'h08, "R2 start again");
    wr(3'd0, 8'h40);
    op(8'hC4, 8'h20, "R3 addr write nack");
    op(8'hE4, 8'h10, "R2 repeated start");
    wr(3'd0, 8'hB5);
    op(8'hC4, 8'h40, "R4 addr read ack");
    fork
      op(8'hC4, 8'h50, "R5 ack kept from byte start");
      begin repeat (30) @(negedge clk); wr(3'd1, 8'hC0); end
    join
    rd(3'd0, v); ck("R4 first read byte", v, 8'hA5);
    op(8'hC0, 8'h58, "R4 read nack");
    rd(3'd0, v); ck("R4 second read byte", v, 8'h0F);

    // START and STOP in one write
    s0 = stops;
    op(8'hF0, 8'h08, "R7 stop then start");
    ck("R7 stop before start", stops, s0 + 1);
    wr(3'd0, 8'h21);
    op(8'hC4, 8'h48, "R4 addr read nack");
    wr(3'd1, 8'hD4);
    repeat (40) @(negedge clk);

    // arbitration loss
    op(8'hE4, 8'h08, "R9 start");
    wr(3'd0, 8'hFE);
    rival = 1'b1;
    op(8'hC4, 8'h38, "R9 arbitration lost");
    ck("R9 lines released", {scl_oe, sda_oe}, 0);
    rival = 1'b0;
    wr(3'd1, 8'hC4);
    repeat (20) @(negedge clk);
    ck("R9 idle after clear", {scl_oe, sda_oe, irq}, 0);

    // bus error
    op(8'hE4, 8'h08, "R10 start");
    wr(3'd0, 8'hFF);
    fork
      op(8'hC4, 8'h00, "R10 bus error");
      begin
        do @(negedge clk); while (scl_oe);
        repeat (2) @(negedge clk);
        rival = 1'b1;
      end
    join
    ck("R10 lines released", {scl_oe, sda_oe}, 0);
    rival = 1'b0;
    wr(3'd1, 8'hC4);
    repeat (20) @(negedge clk);

    // soft reset while parked
    wr(3'd3, 8'h09);
    op(8'hE4, 8'h08, "R11 start");
    wr(3'd4, 8'h5A);
    @(negedge clk);
    ck("R11 lines released", {scl_oe, sda_oe, irq}, 0);
    rd(3'd1, v); ck("R11 control cleared", v, 8'h00);
    rd(3'd2, v); ck("R11 status idle", v, 8'hF8);
    rd(3'd3, v); ck("R11 clock setup cleared", v, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule